// File: doc/BRIEF.md
# Cascaded Audio DAC Clock-Enable Divider

This block turns one codec input tick stream into the clock enables an audio DAC needs. It runs entirely on one fast system clock `clk_i`. Each clock rate is carried as a one-cycle enable strobe on that clock, not as a separate clock. A select input picks the codec tick from two sources: a direct system-clock tick or a tick derived from a PLL. Three integer stages are chained on that tick. The first divides by N, the second divides the N strobes by M, and the third counts M strobes up to the oversampling ratio. One sample-rate strobe therefore appears every N×M×OSR codec ticks.

The N strobe is exported so that the DAC clock-generation logic can share it. The N stage and the M stage each have their own power-up input. A powered-down stage emits nothing and holds its counter at zero, so the first strobe after power-up comes only after a full count. The divider fields, power-up bits and required resource count are static inputs.

A combinational check compares the processing budget, (M×OSR)/32, against the resource count that the chosen processing block needs. The sample strobe is held low whenever that check fails. All pins are plain control or strobe signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `acd_top`

## Requirements
- R1: `codec_tick_o` follows `pll_tick_i` when `src_sel_i` is 1 and follows `sys_tick_i` when it is 0.
- R2: With the N stage powered, `n_stb_o` is high on every N-th codec tick, in the same cycle as that tick. A 7-bit `n_div_i` value of 0 means N = 128, and values 1 to 127 mean themselves.
- R3: With both stages powered, `m_stb_o` is high on every M-th N strobe. `m_div_i` is encoded like `n_div_i` (0 means 128).
- R4: The OSR stage counts M strobes. `fs_stb_o` is high on every OSR-th M strobe, which is every N×M×OSR codec ticks from power-up. The 10-bit `osr_i` value of 0 means 1024.
- R5: While `n_pwr_i` is low, `n_stb_o`, `m_stb_o` and `fs_stb_o` stay low and all counters are cleared. After power-up, the first `n_stb_o` comes on the N-th tick.
- R6: While `m_pwr_i` is low, `m_stb_o` and `fs_stb_o` stay low, and `n_stb_o` keeps running.
- R7: `cfg_ok_o` is high exactly when floor(M×OSR/32) ≥ `rc_need_i`, using the decoded M and OSR values.
- R8: `fs_stb_o` stays low whenever `cfg_ok_o` is low, even though `m_stb_o` keeps running.
- R9: While `rst_ni` is low, all counters are held at zero, and no strobe appears for divider values above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sys_tick_i | input | 1 | Codec tick taken directly from the system clock source |
| pll_tick_i | input | 1 | Codec tick taken from the PLL output |
| src_sel_i | input | 1 | Source select: 1 picks the PLL tick, 0 picks the system tick |
| n_div_i | input | 7 | N ratio field (0 means 128) |
| n_pwr_i | input | 1 | N stage power-up |
| m_div_i | input | 7 | M ratio field (0 means 128) |
| m_pwr_i | input | 1 | M stage power-up |
| osr_i | input | 10 | Oversampling ratio field (0 means 1024) |
| rc_need_i | input | 8 | Resource count required by the processing block |
| codec_tick_o | output | 1 | Selected codec tick |
| n_stb_o | output | 1 | N-stage strobe, shared with DAC clock generation |
| m_stb_o | output | 1 | M-stage strobe |
| fs_stb_o | output | 1 | Sample-rate strobe |
| cfg_ok_o | output | 1 | Resource budget satisfied |

## Verification
The bench uses the default widths: 7-bit dividers, a 10-bit OSR and an 8-bit resource count. These widths let it reach both encoded-maximum corners directly: N = 128 from a zero field and OSR = 1024 from a zero field. At OSR = 1024 with M = 1, the budget lands exactly on 32. A resource count of 32 then passes and a count of 33 fails, which tests the comparison at its edge. Small ratios keep each period short, so every strobe in a window can be counted.

// File: rtl/acd_pkg.sv
package acd_pkg;
  typedef enum logic {SRC_SYS = 1'b0, SRC_PLL = 1'b1} acd_src_e;
endpackage

// File: rtl/acd_stage.sv
module acd_stage #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pwr_i,
  input  logic         in_stb_i,
  input  logic [W-1:0] field_i,
  output logic         out_stb_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;
  logic         hit;

  // field 0 wraps to all ones: a ratio of 2**W
  assign last      = field_i - 1'b1;
  assign hit       = (cnt_q == last);
  assign out_stb_o = pwr_i & in_stb_i & hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !pwr_i) begin
      cnt_q <= '0;
    end else if (in_stb_i) begin
      if (hit || cnt_q > last) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_CLR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pwr_i) |-> cnt_q == '0); // R5
  AST_CNT_ZERO_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(out_stb_o) |-> cnt_q == '0); // R2
endmodule

// File: rtl/acd_budget.sv
module acd_budget #(
  parameter int DIV_W = 7,
  parameter int OSR_W = 10,
  parameter int RC_W  = 8,
  parameter int SHIFT = 5
) (
  input  logic [DIV_W-1:0] m_div_i,
  input  logic [OSR_W-1:0] osr_i,
  input  logic [RC_W-1:0]  rc_need_i,
  output logic             ok_o
);
  localparam int PW = DIV_W + OSR_W + 2;

  logic [DIV_W:0] m_ratio;
  logic [OSR_W:0] osr_ratio;
  logic [PW-1:0]  prod;
  logic [PW-1:0]  budget;

  assign m_ratio   = {m_div_i == '0, m_div_i};
  assign osr_ratio = {osr_i == '0, osr_i};
  assign prod      = PW'(m_ratio) * PW'(osr_ratio);
  assign budget    = prod >> SHIFT;
  assign ok_o      = budget >= PW'(rc_need_i);
endmodule

// File: rtl/acd_top.sv
module acd_top #(
  parameter int DIV_W = 7,
  parameter int OSR_W = 10,
  parameter int RC_W  = 8,
  parameter int SHIFT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_tick_i,
  input  logic             pll_tick_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] n_div_i,
  input  logic             n_pwr_i,
  input  logic [DIV_W-1:0] m_div_i,
  input  logic             m_pwr_i,
  input  logic [OSR_W-1:0] osr_i,
  input  logic [RC_W-1:0]  rc_need_i,
  output logic             codec_tick_o,
  output logic             n_stb_o,
  output logic             m_stb_o,
  output logic             fs_stb_o,
  output logic             cfg_ok_o
);
  import acd_pkg::*;

  logic osr_stb;
  logic osr_pwr;

  assign codec_tick_o = (acd_src_e'(src_sel_i) == SRC_PLL) ? pll_tick_i : sys_tick_i;
  assign osr_pwr      = n_pwr_i & m_pwr_i;

  acd_stage #(.W(DIV_W)) n_stage_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(n_pwr_i),
    .in_stb_i(codec_tick_o), .field_i(n_div_i), .out_stb_o(n_stb_o));

  acd_stage #(.W(DIV_W)) m_stage_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(osr_pwr),
    .in_stb_i(n_stb_o), .field_i(m_div_i), .out_stb_o(m_stb_o));

  acd_stage #(.W(OSR_W)) osr_stage_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(osr_pwr),
    .in_stb_i(m_stb_o), .field_i(osr_i), .out_stb_o(osr_stb));

  acd_budget #(.DIV_W(DIV_W), .OSR_W(OSR_W), .RC_W(RC_W), .SHIFT(SHIFT)) budget_i (
    .m_div_i(m_div_i), .osr_i(osr_i), .rc_need_i(rc_need_i), .ok_o(cfg_ok_o));

  assign fs_stb_o = osr_stb & cfg_ok_o;

  AST_FS_IN_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_stb_o |-> (m_stb_o && n_stb_o && codec_tick_o)); // R4
  AST_FS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok_o |-> !fs_stb_o); // R8
  AST_N_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_pwr_i |-> !(n_stb_o || m_stb_o || fs_stb_o)); // R5
  AST_M_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_pwr_i |-> !(m_stb_o || fs_stb_o)); // R6
endmodule

// File: tb/acd_top_tb_top.sv
module acd_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_tick = 1'b0, pll_tick = 1'b0, sel = 1'b0;
  logic [6:0] n_div = 7'd2, m_div = 7'd1;
  logic n_pwr = 1'b0, m_pwr = 1'b0;
  logic [9:0] osr = 10'd1;
  logic [7:0] rc = 8'd0;
  logic codec_tick, n_stb, m_stb, fs_stb, cfg_ok;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_tick_i(sys_tick), .pll_tick_i(pll_tick),
    .src_sel_i(sel), .n_div_i(n_div), .n_pwr_i(n_pwr), .m_div_i(m_div),
    .m_pwr_i(m_pwr), .osr_i(osr), .rc_need_i(rc), .codec_tick_o(codec_tick),
    .n_stb_o(n_stb), .m_stb_o(m_stb), .fs_stb_o(fs_stb), .cfg_ok_o(cfg_ok));

  // {n, m, osr, rc}
  localparam logic [31:0] VEC [4] = '{
    {7'd2, 7'd3,  10'd4, 8'd0},
    {7'd1, 7'd32, 10'd1, 8'd1},
    {7'd3, 7'd1,  10'd5, 8'd1},
    {7'd0, 7'd1,  10'd1, 8'd0}
  };

  function automatic int dec(input int f, input int full);
    return (f == 0) ? full : f;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // power-cycle, then apply t ticks (one per cycle), counting strobes
  task automatic run(input int t, output int nc, output int mc, output int fc, output int first);
    nc = 0; mc = 0; fc = 0; first = 0;
    @(negedge clk); n_pwr = 1'b0; m_pwr = 1'b0; sys_tick = 1'b0; sel = 1'b0;
    @(negedge clk); @(negedge clk);
    n_pwr = 1'b1; m_pwr = 1'b1; sys_tick = 1'b1;
    for (int k = 1; k <= t; k++) begin
      #1;
      if (n_stb) nc++;
      if (m_stb) mc++;
      if (fs_stb) begin fc++; if (first == 0) first = k; end
      @(negedge clk);
    end
    sys_tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nc, mc, fc, first, nn, mm, oo, rr, per, t;
    bit ok;
    // R9: reset state with N=2, powered, ticking
    n_div = 7'd2; n_pwr = 1'b1; m_pwr = 1'b1; sys_tick = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 n_stb in reset", int'(n_stb), 0);
    chk("R9 fs_stb in reset", int'(fs_stb), 0);
    @(negedge clk); rst_n = 1'b1; n_pwr = 1'b0; m_pwr = 1'b0; sys_tick = 1'b0;

    // table: R2 R3 R4 R7 R8
    foreach (VEC[i]) begin
      nn = dec(int'(VEC[i][31:25]), 128);
      mm = dec(int'(VEC[i][24:18]), 128);
      oo = dec(int'(VEC[i][17:8]), 1024);
      rr = int'(VEC[i][7:0]);
      n_div = VEC[i][31:25]; m_div = VEC[i][24:18]; osr = VEC[i][17:8]; rc = VEC[i][7:0];
      ok = ((mm * oo) / 32) >= rr;
      per = nn * mm * oo;
      t = ok ? per : 200;
      run(t, nc, mc, fc, first);
      #1;
      chk("R7 cfg_ok", int'(cfg_ok), int'(ok));
      chk("R2 n strobes", nc, t / nn);
      chk("R3 m strobes", mc, t / (nn * mm));
      chk("R4/R8 fs strobes", fc, ok ? 1 : 0);
      if (ok) chk("R4 fs period", first, per);
    end

    // R4 R7: OSR field 0 is 1024, budget exactly 32
    n_div = 7'd1; m_div = 7'd1; osr = 10'd0; rc = 8'd32;
    run(1024, nc, mc, fc, first);
    chk("R4 osr 1024 period", first, 1024);
    chk("R7 budget 32 passes", int'(cfg_ok), 1);
    rc = 8'd33; #1;
    chk("R7 budget 32 vs 33 fails", int'(cfg_ok), 0);

    // R5: N powered down
    n_div = 7'd2; m_div = 7'd1; osr = 10'd1; rc = 8'd0;
    @(negedge clk); n_pwr = 1'b0; m_pwr = 1'b1; sys_tick = 1'b1;
    nc = 0; mc = 0; fc = 0;
    for (int k = 0; k < 20; k++) begin
      #1; nc += int'(n_stb); mc += int'(m_stb); fc += int'(fs_stb);
      @(negedge clk);
    end
    chk("R5 no strobes while N off", nc + mc + fc, 0);
    // R5: first strobe after power-up on the 2nd tick
    n_pwr = 1'b1; #1;
    chk("R5 no strobe on first tick", int'(n_stb), 0);
    @(negedge clk); #1;
    chk("R5 strobe on Nth tick", int'(n_stb), 1);

    // R6: M powered down, N keeps running
    @(negedge clk); m_pwr = 1'b0;
    nc = 0; mc = 0; fc = 0;
    for (int k = 0; k < 20; k++) begin
      #1; nc += int'(n_stb); mc += int'(m_stb); fc += int'(fs_stb);
      @(negedge clk);
    end
    chk("R6 n runs while M off", nc, 10);
    chk("R6 no m/fs while M off", mc + fc, 0);
    sys_tick = 1'b0; n_pwr = 1'b0;

    // R1: source select
    @(negedge clk); sel = 1'b1; sys_tick = 1'b1; pll_tick = 1'b0; #1;
    chk("R1 pll selected low", int'(codec_tick), 0);
    pll_tick = 1'b1; sys_tick = 1'b0; #1;
    chk("R1 pll selected high", int'(codec_tick), 1);
    sel = 1'b0; #1;
    chk("R1 sys selected", int'(codec_tick), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule